// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block raises a periodic interrupt toward a host processor. It counts no time of its own. A timekeeping datapath elsewhere in the chip supplies one single-cycle pulse for each of six cadences: half-second, second, minute, hour, day and month. A 3-bit period select chooses which of these pulses sets the interrupt. The other select codes turn generation off.

When the chosen pulse arrives, the block sets a sticky flag that the host can read. While generation is enabled, the block also drives an active-low interrupt line. The host acknowledges the interrupt with a one-cycle clear strobe. A halt input suspends generation without losing the flag. Its main users are firmware wake-up timers and periodic housekeeping tasks that must align to calendar boundaries rather than to a free-running divider.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block ignores pulses for the first two clock edges after the reset input goes high.

Top module: `periodic_irq_gen`

## Requirements
- R1: Reset state: after reset the flag output `irq_flag` reads 0 and `irq_n` reads 1.
- R2: Pulse mapping: with `period_sel` = k, where k is 1 to 6, and `halt` low, a high `tick_vec[k-1]` at a clock edge sets `irq_flag` from that edge onward. The `tick_vec` bits map as follows: bit 0 is the half-second pulse, bit 1 the second, bit 2 the minute, bit 3 the hour, bit 4 the day and bit 5 the month.
- R3: With `period_sel` in 1 to 6, a pulse on any `tick_vec` bit other than bit k-1 leaves `irq_flag` unchanged.
- R4: Select codes 0 and 7 disable generation. No `tick_vec` bit sets the flag, and `irq_n` stays high.
- R5: Once set, `irq_flag` stays set, whatever the pulses and the select, until `flag_clr` is seen high at a clock edge.
- R6: Clearing: `flag_clr` high at an edge with no qualifying pulse clears `irq_flag` from that edge onward.
- R7: Collision: if `flag_clr` and a qualifying pulse are both high at the same edge, `irq_flag` stays set.
- R8: `irq_n` is low exactly when `irq_flag` is 1, `halt` is 0, and `period_sel` is in 1 to 6.
- R9: Halt behaviour: while `halt` is high, no pulse sets the flag and `irq_n` stays high. A flag that was already set is kept, and `irq_n` drops again once `halt` is released.
- R10: Select changes: writing a new `period_sel` value never sets the flag by itself. Only a later qualifying pulse does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_vec | input | 6 | Single-cycle cadence pulses; bit 0 = half-second through bit 5 = month |
| period_sel | input | 3 | Period select: 1 to 6 pick `tick_vec[0]` to `tick_vec[5]`; 0 and 7 disable |
| halt | input | 1 | Suspends generation and masks `irq_n` |
| flag_clr | input | 1 | Host clear strobe for the sticky flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The main sweep crosses all eight select codes with a pulse on each of the six cadence bits, one bit at a time. Each cell separates a correct mapping from an off-by-one or swapped mapping, and confirms that codes 0 and 7 are dead. A second pass repeats the pulses with `halt` high, which separates masking of the set path from masking of the output alone. Targeted sequences then cover the corner cases. One has clear and pulse at the same edge, which tells set-priority from clear-priority. One sweeps the select while a flag is held, which exposes flags that stick or get lost. One changes the select with no pulse present, which catches a design that fires on select writes.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned SEL_W   = 3;

  // true when a select code names one of the cadence sources
  function automatic logic sel_active(input logic [SEL_W-1:0] code);
    return (code != '0) && (int'(code) <= int'(NUM_SRC));
  endfunction
endpackage

// File: rtl/pirq_rst_sync.sv
module pirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pirq_evt_sel.sv
module pirq_evt_sel
  import pirq_pkg::*;
#(
  parameter int unsigned SRCS = NUM_SRC,
  parameter int unsigned SW   = SEL_W
) (
  input  logic [SRCS-1:0] tick_vec,
  input  logic [SW-1:0]   period_sel,
  input  logic            halt,
  output logic            gen_en,
  output logic            evt_hit
);
  logic [SRCS-1:0] match_vec;

  for (genvar i = 0; i < SRCS; i++) begin : g_src
    localparam logic [SW-1:0] CODE = SW'(i + 1);
    assign match_vec[i] = tick_vec[i] & (period_sel == CODE);
  end

  assign gen_en  = ~halt & (|{period_sel != '0} & (int'(period_sel) <= int'(SRCS)));
  assign evt_hit = ~halt & (|match_vec);
endmodule

// File: rtl/pirq_flag.sv
module pirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  // set takes priority over clear
  always_comb begin
    flag_d  = flag_q;
    flag_en = set_i | clr_i;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pirq_pkg::*;
#(
  parameter int unsigned SRCS = NUM_SRC,
  parameter int unsigned SW   = SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SRCS-1:0] tick_vec,
  input  logic [SW-1:0]   period_sel,
  input  logic            halt,
  input  logic            flag_clr,
  output logic            irq_flag,
  output logic            irq_n
);
  logic rst_sync_n;
  logic gen_en;
  logic evt_hit;

  pirq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pirq_evt_sel #(.SRCS(SRCS), .SW(SW)) u_sel (
    .tick_vec   (tick_vec),
    .period_sel (period_sel),
    .halt       (halt),
    .gen_en     (gen_en),
    .evt_hit    (evt_hit)
  );

  pirq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (evt_hit),
    .clr_i  (flag_clr),
    .flag_o (irq_flag)
  );

  assign irq_n = ~(irq_flag & gen_en);
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
  parameter int unsigned SRCS = 6,
  parameter int unsigned SW   = 3
) (
  input logic            clk,
  input logic            rst_ok,
  input logic [SRCS-1:0] tick_vec,
  input logic [SW-1:0]   period_sel,
  input logic            halt,
  input logic            flag_clr,
  input logic            irq_flag,
  input logic            irq_n
);
  logic sel_on;
  logic hit;
  assign sel_on = (period_sel != '0) && (int'(period_sel) <= int'(SRCS));
  assign hit    = !halt && sel_on && tick_vec[period_sel - SW'(1)];

  // R2
  set_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    hit |=> irq_flag);
  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!irq_flag && !hit) |=> !irq_flag);
  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_flag && !flag_clr) |=> irq_flag);
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (flag_clr && !hit) |=> !irq_flag);
  // R7
  collide_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (flag_clr && hit) |=> irq_flag);
  // R9
  halt_mask_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    halt |-> irq_n);
  // R4
  off_code_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !sel_on |-> irq_n);
endmodule

bind periodic_irq_gen pirq_chk #(.SRCS(SRCS), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .tick_vec   (tick_vec),
  .period_sel (period_sel),
  .halt       (halt),
  .flag_clr   (flag_clr),
  .irq_flag   (irq_flag),
  .irq_n      (irq_n)
);

// File: tb/periodic_irq_gen_test.sv
module periodic_irq_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] tick_vec;
  logic [2:0] period_sel;
  logic       halt;
  logic       flag_clr;
  logic       irq_flag;
  logic       irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  periodic_irq_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_vec(tick_vec), .period_sel(period_sel),
    .halt(halt), .flag_clr(flag_clr), .irq_flag(irq_flag), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one clock: inputs applied now are seen at the next posedge,
  // results are sampled at the following negedge
  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic pulse(input int bitn);
    tick_vec = 6'(1 << bitn);
    cycle();
    tick_vec = '0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    cycle();
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_vec = '0; period_sel = '0; halt = 1'b0; flag_clr = 1'b0;
    repeat (3) cycle();
    // R1
    check("R1 flag", irq_flag, 1'b0);
    check("R1 irq_n", irq_n, 1'b1);
    rst_n = 1'b1;
    repeat (3) cycle();
    check("R1 flag after release", irq_flag, 1'b0);

    // sweep select x source: R2, R3, R4, R8
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 6; b++) begin
        logic exp;
        exp = (s >= 1 && s <= 6 && b == s - 1);
        period_sel = 3'(s);
        cycle();
        pulse(b);
        check(exp ? "R2 set" : (s == 0 || s == 7) ? "R4 off" : "R3 other", irq_flag, exp);
        check("R8 irq_n", irq_n, ~exp);
        clear_flag();
        check("R6 cleared", irq_flag, 1'b0);
      end
    end

    // R10: select changes alone never set the flag
    for (int s = 0; s < 8; s++) begin
      period_sel = 3'(s);
      cycle();
      check("R10 sel change", irq_flag, 1'b0);
    end

    // R5: sticky across unrelated pulses and select changes
    period_sel = 3'd4; cycle();
    pulse(3);
    for (int s = 0; s < 8; s++) begin
      period_sel = 3'(s);
      pulse(s % 6);
      check("R5 sticky", irq_flag, 1'b1);
      check("R8 irq_n", irq_n, !(s >= 1 && s <= 6));
    end
    period_sel = 3'd4;
    cycle();
    clear_flag();
    check("R6 clear", irq_flag, 1'b0);

    // R7: clear and qualifying pulse together
    period_sel = 3'd6;
    tick_vec = 6'b100000; flag_clr = 1'b1;
    cycle();
    tick_vec = '0; flag_clr = 1'b0;
    check("R7 collide", irq_flag, 1'b1);
    clear_flag();
    // R6: clear with a non-qualifying pulse still clears
    pulse(5);
    tick_vec = 6'b000001; flag_clr = 1'b1;
    cycle();
    tick_vec = '0; flag_clr = 1'b0;
    check("R6 clear with other pulse", irq_flag, 1'b0);

    // R9: halt blocks set, masks output, keeps flag
    for (int s = 1; s <= 6; s++) begin
      period_sel = 3'(s);
      halt = 1'b1;
      cycle();
      pulse(s - 1);
      check("R9 halt blocks set", irq_flag, 1'b0);
      check("R9 halt irq_n", irq_n, 1'b1);
      halt = 1'b0;
      pulse(s - 1);
      halt = 1'b1;
      cycle();
      check("R9 flag kept", irq_flag, 1'b1);
      check("R9 masked", irq_n, 1'b1);
      halt = 1'b0;
      cycle();
      check("R9 unmasked", irq_n, 1'b0);
      clear_flag();
    end

    finish_run();
  end
endmodule